// File: doc/BRIEF.md
# Bus Write Activity Status Timer

This block produces an 8-bit status word that tells software about recent word writes on an external bus. Every write pulses a strobe into the block. A free-running tick enable advances time. Three flag bits in the status word then rise and fall on fixed windows measured in ticks. An activity flag is set at once and drops shortly after the last write. A mid-range flag turns on after a delay and is shown only close to the end of its window. A late flag turns on well after the write and stays on for a long hold.

Each window is kept as a relative down-counter that saturates at zero. Because of that, time never wraps. A write that comes while a window is still running makes that window longer; it does not start it again. Bits 3:1 of the status word always read 1. The other bits that are not flags always read 0.

Top module: `wst_status_timer`

## Requirements
- R1: Status bit 5 (activity flag) is 1 from the cycle after any write strobe. It returns to 0 once ACT_HOLD (default 8) ticks have passed with no further write.
- R2: A write that finds the mid window expired (off time reached) sets the bit 4 on time MID_DELAY (default 8) ticks after the write. Bit 4 reads 0 before that point.
- R3: Each write sets the bit 4 off time to MID_STEP (default 16) ticks past the later of now and the pending off time. Bit 4 reads 0 once that off time is reached.
- R4: Bit 4 reads 1 only when its off time is still ahead by at most MID_NEAR (default 8) ticks and its on time has been reached. Otherwise it reads 0.
- R5: A write while the late window is idle makes bit 0 turn on LATE_DELAY (default 24) ticks later. Bit 0 then turns off LATE_HOLD (default 24) ticks after that.
- R6: A write while the late window is active adds LATE_HOLD ticks to the remaining bit 0 off time and leaves its on time unchanged.
- R7: Status bits 3:1 always read 3'b111. Bits 7:6 always read 0.
- R8: After reset every window is cleared, so the status reads 8'h0E.
- R9: When a write and a tick arrive in the same cycle, the write is applied and that tick is dropped. The new windows begin counting on the next tick.
- R10: In a cycle with neither a tick nor a write, the status does not change.
- R11: A window length that would go past 2^CNT_W-1 ticks is clamped to 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable; one tick per asserted cycle |
| wr_i | input | 1 | Bus word write strobe |
| status_o | output | 8 | Status word: bit 5 activity, bit 4 mid flag, bit 0 late flag, bits 3:1 fixed 1 |

## Verification
The bench builds the block with its default window lengths and an 8-bit counter width. With that width, a burst of twenty writes and no ticks pushes both the mid and the late off times past 255. This brings the clamping of R11 within a few hundred ticks. An absolute-time model in the bench follows every step of a vector table and of directed sequences. Those sequences include windows stretched by back-to-back writes, late-window extension while active, and a write and a tick in the same cycle.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_ACT  = 5;
  localparam int unsigned BIT_MID  = 4;
  localparam int unsigned BIT_LATE = 0;

  // Add with clamp at lim.
  function automatic int unsigned wst_sat_add(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // Decrement, saturating at zero.
  function automatic int unsigned wst_dec(input int unsigned a);
    return (a == 0) ? 0 : a - 1;
  endfunction
endpackage

// File: rtl/wst_hold_flag.sv
module wst_hold_flag #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned HOLD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  output logic flag_o
);
  import wst_pkg::*;
  localparam int unsigned LIM = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (wr_i)   left_q <= CNT_W'(wst_sat_add(HOLD, 0, LIM));
    else if (tick_i) left_q <= CNT_W'(wst_dec(32'(left_q)));
  end

  assign flag_o = (left_q != '0);
endmodule

// File: rtl/wst_mid_flag.sv
module wst_mid_flag #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DELAY = 8,
  parameter int unsigned STEP  = 16,
  parameter int unsigned NEAR  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  output logic flag_o,
  output logic expired_o
);
  import wst_pkg::*;
  localparam int unsigned LIM = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] on_q, off_q;

  assign expired_o = (off_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      off_q <= '0;
    end else if (wr_i) begin
      if (expired_o) on_q <= CNT_W'(wst_sat_add(DELAY, 0, LIM));
      off_q <= CNT_W'(wst_sat_add(32'(off_q), STEP, LIM));
    end else if (tick_i) begin
      on_q  <= CNT_W'(wst_dec(32'(on_q)));
      off_q <= CNT_W'(wst_dec(32'(off_q)));
    end
  end

  assign flag_o = !expired_o && (32'(off_q) <= NEAR) && (on_q == '0);
endmodule

// File: rtl/wst_late_flag.sv
module wst_late_flag #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DELAY = 24,
  parameter int unsigned HOLD  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  output logic flag_o,
  output logic idle_o
);
  import wst_pkg::*;
  localparam int unsigned LIM = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] on_q, off_q;

  assign idle_o = (off_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      off_q <= '0;
    end else if (wr_i) begin
      if (idle_o) begin
        on_q  <= CNT_W'(wst_sat_add(DELAY, 0, LIM));
        off_q <= CNT_W'(wst_sat_add(DELAY, HOLD, LIM));
      end else begin
        off_q <= CNT_W'(wst_sat_add(32'(off_q), HOLD, LIM));
      end
    end else if (tick_i) begin
      on_q  <= CNT_W'(wst_dec(32'(on_q)));
      off_q <= CNT_W'(wst_dec(32'(off_q)));
    end
  end

  assign flag_o = !idle_o && (on_q == '0);
endmodule

// File: rtl/wst_status_timer.sv
module wst_status_timer #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ACT_HOLD   = 8,
  parameter int unsigned MID_DELAY  = 8,
  parameter int unsigned MID_STEP   = 16,
  parameter int unsigned MID_NEAR   = 8,
  parameter int unsigned LATE_DELAY = 24,
  parameter int unsigned LATE_HOLD  = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_i,
  output logic [7:0] status_o
);
  import wst_pkg::*;

  logic act_flag, mid_flag, late_flag;
  logic mid_expired, late_idle;

  wst_hold_flag #(.CNT_W(CNT_W), .HOLD(ACT_HOLD)) u_act (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .flag_o(act_flag));

  wst_mid_flag #(.CNT_W(CNT_W), .DELAY(MID_DELAY), .STEP(MID_STEP), .NEAR(MID_NEAR)) u_mid (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
    .flag_o(mid_flag), .expired_o(mid_expired));

  wst_late_flag #(.CNT_W(CNT_W), .DELAY(LATE_DELAY), .HOLD(LATE_HOLD)) u_late (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
    .flag_o(late_flag), .idle_o(late_idle));

  always_comb begin
    status_o           = '0;
    status_o[3:1]      = 3'b111;
    status_o[BIT_ACT]  = act_flag;
    status_o[BIT_MID]  = mid_flag;
    status_o[BIT_LATE] = late_flag;
  end
endmodule

// File: rtl/wst_status_timer_chk.sv
module wst_status_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_i,
  input logic [7:0] status_o,
  input logic       mid_expired,
  input logic       late_idle
);
  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3:1] == 3'b111 && status_o[7:6] == 2'b00);

  a_r1_act_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> status_o[5]);

  a_r2_mid_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && mid_expired |=> !status_o[4]);

  a_r5_late_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && late_idle |=> !status_o[0]);

  a_r10_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i && !tick_i |=> $stable(status_o));

  a_r4_mid_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i && !tick_i |=> !$rose(status_o[4]));

  a_r6_late_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !$fell(status_o[0]));
endmodule

bind wst_status_timer wst_status_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .status_o(status_o),
  .mid_expired(mid_expired), .late_idle(late_idle));

// File: tb/sim_wst_status_timer.sv
module sim_wst_status_timer;
  localparam int PERIOD = 10;
  localparam int MAXC   = 255;

  logic clk = 0, rst_n = 0, tick_i = 0, wr_i = 0;
  logic [7:0] status_o;
  int n_run = 0, n_fail = 0;

  // absolute-time model
  int now, o5, on4, o4, on0, o0;

  wst_status_timer #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .status_o(status_o));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  function automatic logic [7:0] expect_status();
    logic [7:0] v;
    v = 8'h0E;
    v[5] = (o5 > now);
    v[4] = (o4 > now) && (o4 - now <= 8) && (on4 <= now);
    v[0] = (o0 > now) && (on0 <= now);
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    now = 0; o5 = 0; on4 = 0; o4 = 0; on0 = 0; o0 = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_i = 0; tick_i = 0;
    @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  // One cycle; model compares every bit afterwards.
  task automatic step(input logic w, input logic t);
    logic [7:0] e;
    @(negedge clk); wr_i = w; tick_i = t;
    @(posedge clk); #1;
    if (w) begin
      o5 = now + 8;
      if (o4 <= now) on4 = now + 8;
      o4 = mn(mx(now, o4) + 16, now + MAXC);
      if (o0 <= now) begin on0 = now + 24; o0 = mn(now + 48, now + MAXC); end
      else o0 = mn(o0 + 24, now + MAXC);
    end else if (t) now++;
    e = expect_status();
    chk("R1", {7'b0, status_o[5]}, {7'b0, e[5]});
    chk("R4", {7'b0, status_o[4]}, {7'b0, e[4]});
    chk("R6", {7'b0, status_o[0]}, {7'b0, e[0]});
    chk("R7", status_o & 8'hCE, 8'h0E);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1);
  endtask

  // vector table: {wr, tick}
  localparam logic [1:0] VEC [32] = '{
    2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b01, 2'b00, 2'b01,
    2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b01, 2'b10, 2'b10, 2'b01, 2'b01, 2'b00, 2'b01, 2'b01,
    2'b01, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01};

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset", status_o, 8'h0E);

    for (int k = 0; k < 32; k++) step(VEC[k][1], VEC[k][0]);
    ticks(80);

    // R1: activity hold
    do_reset();
    step(1, 0); ticks(7);
    chk("R1 still set", status_o[5], 1'b1);
    ticks(1);
    chk("R1 cleared", status_o[5], 1'b0);

    // R2/R3/R5: single write
    do_reset();
    step(1, 0); ticks(7);
    chk("R2 before on", status_o[4], 1'b0);
    ticks(1);
    chk("R2 on", status_o[4], 1'b1);
    ticks(7);
    chk("R3 last on", status_o[4], 1'b1);
    ticks(1);
    chk("R3 off", status_o[4], 1'b0);
    ticks(7);
    chk("R5 before on", status_o[0], 1'b0);
    ticks(1);
    chk("R5 on", status_o[0], 1'b1);
    ticks(23);
    chk("R5 last on", status_o[0], 1'b1);
    ticks(1);
    chk("R5 off", status_o[0], 1'b0);

    // R4/R3: back-to-back writes stretch the mid window
    do_reset();
    step(1, 0); step(1, 0); ticks(8);
    chk("R4 far from off", status_o[4], 1'b0);
    ticks(16);
    chk("R4 near off", status_o[4], 1'b1);
    ticks(7);
    chk("R3 stretched last", status_o[4], 1'b1);
    ticks(1);
    chk("R3 stretched off", status_o[4], 1'b0);

    // R6: extend active late window
    do_reset();
    step(1, 0); ticks(30);
    chk("R6 active", status_o[0], 1'b1);
    step(1, 0);
    chk("R6 stays on", status_o[0], 1'b1);
    ticks(41);
    chk("R6 extended", status_o[0], 1'b1);
    ticks(1);
    chk("R6 extended off", status_o[0], 1'b0);

    // R9: write with tick in same cycle
    do_reset();
    step(1, 1); ticks(7);
    chk("R9 tick dropped", status_o[5], 1'b1);
    ticks(1);
    chk("R9 off", status_o[5], 1'b0);

    // R10: no tick holds status
    do_reset();
    step(1, 0);
    for (int i = 0; i < 5; i++) step(0, 0);
    chk("R10 held", status_o, 8'h2E);

    // R11: clamp
    do_reset();
    for (int i = 0; i < 20; i++) step(1, 0);
    ticks(246);
    chk("R11 mid far", status_o[4], 1'b0);
    ticks(1);
    chk("R11 mid near", status_o[4], 1'b1);
    ticks(7);
    chk("R11 late last", status_o[0], 1'b1);
    ticks(1);
    chk("R11 late off", status_o[0], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule